// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Register Window

This block holds the I/O-visible registers of a pair of bus-master DMA channels for a disk controller. The two channels sit side by side in a 16-byte window: channel 0 answers at offsets 0 to 7 and channel 1 at offsets 8 to 15. Each channel has a command byte, a status byte and a 32-bit pointer to its descriptor table. Software starts and stops a transfer by writing the command byte. The block turns those writes into one-cycle start and cancel pulses for a separate DMA engine. The engine in turn reports completion, errors and interrupts back into the status byte.

The pointer accepts byte, 16-bit and 32-bit accesses at any byte lane of the channel's upper four offsets. Its two lowest bits are forced to zero. Its value is presented to the engine as the current table address. An optional extension, selected by a parameter, maps two extra bytes into each channel:
- a shared interrupt mode byte, which merges the two drives' interrupt lines through per-channel block bits into one interrupt output;
- a per-channel timing byte.

Without the extension, those offsets read as all ones.

Top module: `bmdma_regs`

## Requirements
- R1: After reset the command, status, pointer and timing registers read 0, the mode byte reads 0, and no start, cancel or interrupt output is active.
- R2: A write to offset 0 of a channel keeps only bits 0 (run) and 3 (direction) of the value; the direction output of that channel equals stored bit 3.
- R3: A command write with bit 0 set, while the channel's active bit (status bit 0) is clear, sets the active bit and gives a one-cycle start pulse on that channel's start output. If the active bit is already set, no pulse is given.
- R4: A command write with bit 0 clear gives a one-cycle cancel pulse and clears the active bit.
- R5: A write to offset 2 loads status bits 6:5 from the value, leaves bit 0 unchanged, clears each of bits 2:1 written as one, and bits 7, 4 and 3 always read 0.
- R6: The engine's done input clears the active bit, and its error and interrupt inputs set status bits 1 and 2. A set in the same cycle as a write-one-to-clear wins. A start write wins over a same-cycle done.
- R7: Offsets 4 to 7 hold the pointer. Size code 0 is byte and 1 is 16-bit; both place right-justified data at byte lane (offset mod 4), and 16-bit accesses drop lanes above 3. Size codes 2 and 3 (32-bit) use the whole pointer whatever the lane. Reads extract data the same way.
- R8: Pointer bits 1:0 always read 0, and the table address output shows the new pointer from the cycle after any pointer write.
- R9: When the extension is enabled, offset 1 of either channel accesses the shared mode byte (bit 2+c = drive c interrupt level, bit 4+c = block for channel c; only bits 5:4 are writable), and offset 3 is a writable per-channel timing byte. When it is disabled, both offsets read 0xFF and ignore writes.
- R10: The interrupt output is high when some channel c has its interrupt level bit set and its block bit clear; the level bit samples the drive interrupt input one cycle earlier.
- R11: Channel 1 uses offsets 8 to 15, and its accesses leave channel 0 unchanged.
- R12: Read data and its valid flag appear in the cycle after the read request. Reads of offsets 0 to 3 return the byte zero-extended, whatever the size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_rd | input | 1 | Read request |
| acc_wr | input | 1 | Write request |
| acc_addr | input | 4 | Byte offset in the window |
| acc_size | input | 2 | 0 byte, 1 16-bit, 2 or 3 32-bit |
| acc_wdata | input | 32 | Right-justified write data |
| acc_rdata | output | 32 | Read data, one cycle after the request |
| acc_rvalid | output | 1 | Read data valid |
| eng_done | input | 2 | Per-channel engine completion |
| eng_err | input | 2 | Per-channel engine error |
| eng_intr | input | 2 | Per-channel engine interrupt |
| drv_irq | input | 2 | Per-channel drive interrupt level |
| dma_start | output | 2 | Per-channel start pulse |
| dma_cancel | output | 2 | Per-channel cancel pulse |
| dma_dir | output | 2 | Per-channel direction bit |
| tbl_addr | output | 64 | Table addresses, channel c in bits 32c+31:32c |
| irq_out | output | 1 | Merged interrupt |

## Verification
A corrupted active bit shows one access later: on the next command write it produces a missing or extra start pulse, and a status read at offset 2 shows it directly. Faulty byte-lane steering in the pointer shows on the table address output in the cycle after the write. It also shows in a narrow read-back, so the bench walks every lane and every width. A wrong mode byte shows on the interrupt output within a cycle of a mode write or a change on the drive line.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int PTR_W = 32;

    localparam logic [7:0]       CMD_KEEP   = 8'h09;
    localparam logic [7:0]       ST_LOADED  = 8'h60;
    localparam logic [7:0]       UNMAPPED   = 8'hFF;
    localparam logic [PTR_W-1:0] PTR_KEEP   = 32'hFFFF_FFFC;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic [7:0]       cmd;
        logic [7:0]       st;
        logic [PTR_W-1:0] ptr;
        logic [7:0]       tim;
        logic             start;
        logic             cancel;
    } chan_regs_t;

    // Byte-lane mask of an access; wide accesses always cover the whole word.
    function automatic logic [PTR_W-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] lane);
        logic [PTR_W-1:0] m;
        if (sz >= SZ_DWORD) begin
            m = '1;
        end else if (sz == SZ_WORD) begin
            m = 32'h0000_FFFF << {lane, 3'b000};
        end else begin
            m = 32'h0000_00FF << {lane, 3'b000};
        end
        return m;
    endfunction

endpackage

// File: rtl/bmdma_chan.sv
module bmdma_chan
    import bmdma_pkg::*;
#(
    parameter bit HAS_EXT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       off,
    input  logic [1:0]       size,
    input  logic [PTR_W-1:0] wdata,
    input  logic             eng_done,
    input  logic             eng_err,
    input  logic             eng_intr,
    output logic [7:0]       cmd_o,
    output logic [7:0]       st_o,
    output logic [7:0]       tim_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic             start_o,
    output logic             cancel_o
);

    chan_regs_t       r_d, r_q;
    logic [PTR_W-1:0] lmask_d;
    logic [4:0]       shift_d;

    always_comb begin
        r_d        = r_q;
        r_d.start  = 1'b0;
        r_d.cancel = 1'b0;
        lmask_d    = lane_mask(size, off[1:0]);
        shift_d    = (size >= SZ_DWORD) ? 5'd0 : {off[1:0], 3'b000};

        if (eng_done) begin
            r_d.st[0] = 1'b0;
        end

        if (wr_en) begin
            if (off[2]) begin
                r_d.ptr = ((r_q.ptr & ~lmask_d) | ((wdata << shift_d) & lmask_d)) & PTR_KEEP;
            end else begin
                case (off[1:0])
                    2'd0: begin
                        r_d.cmd = wdata[7:0] & CMD_KEEP;
                        if (!wdata[0]) begin
                            r_d.cancel = 1'b1;
                            r_d.st[0]  = 1'b0;
                        end else if (!r_q.st[0]) begin
                            r_d.start  = 1'b1;
                            r_d.st[0]  = 1'b1;
                        end
                    end
                    2'd2: begin
                        r_d.st[7]   = 1'b0;
                        r_d.st[6:5] = wdata[6:5];
                        r_d.st[4:3] = 2'b00;
                        r_d.st[2:1] = r_q.st[2:1] & ~wdata[2:1];
                    end
                    2'd3: begin
                        if (HAS_EXT) begin
                            r_d.tim = wdata[7:0];
                        end
                    end
                    default: ;
                endcase
            end
        end

        // engine reports override a same-cycle clear
        if (eng_err) begin
            r_d.st[1] = 1'b1;
        end
        if (eng_intr) begin
            r_d.st[2] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_o    = r_q.cmd;
    assign st_o     = r_q.st;
    assign tim_o    = r_q.tim;
    assign ptr_o    = r_q.ptr;
    assign start_o  = r_q.start;
    assign cancel_o = r_q.cancel;

endmodule

// File: rtl/bmdma_mode.sv
module bmdma_mode #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NUM_CH-1:0] blk_wdata,
    input  logic [NUM_CH-1:0] drv_irq,
    output logic [7:0]        mode_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] blk;
        logic [NUM_CH-1:0] lvl;
    } mode_t;

    mode_t m_d, m_q;

    always_comb begin
        m_d     = m_q;
        m_d.lvl = drv_irq;
        if (wr_en) begin
            m_d.blk = blk_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    always_comb begin
        mode_o = 8'h00;
        for (int c = 0; c < NUM_CH; c++) begin
            mode_o[2+c] = m_q.lvl[c];
            mode_o[4+c] = m_q.blk[c];
        end
    end

    assign irq_o = |(m_q.lvl & ~m_q.blk);

endmodule

// File: rtl/bmdma_rdmux.sv
module bmdma_rdmux
    import bmdma_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter bit HAS_EXT = 1'b1,
    localparam int AW     = $clog2(NUM_CH) + 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic [AW-1:0]                addr,
    input  logic [1:0]                   size,
    input  logic [NUM_CH-1:0][7:0]       cmd_v,
    input  logic [NUM_CH-1:0][7:0]       st_v,
    input  logic [NUM_CH-1:0][7:0]       tim_v,
    input  logic [NUM_CH-1:0][PTR_W-1:0] ptr_v,
    input  logic [7:0]                   mode_b,
    output logic [PTR_W-1:0]             rdata_o,
    output logic                         rvalid_o
);

    typedef struct packed {
        logic [PTR_W-1:0] data;
        logic             valid;
    } rd_t;

    rd_t              rd_d, rd_q;
    logic [AW-4:0]    ch_d;
    logic [PTR_W-1:0] ptr_sel_d;
    logic [7:0]       byte_d;

    always_comb begin
        ch_d      = addr[AW-1:3];
        ptr_sel_d = ptr_v[ch_d];
        case (addr[1:0])
            2'd0:    byte_d = cmd_v[ch_d];
            2'd1:    byte_d = HAS_EXT ? mode_b : UNMAPPED;
            2'd2:    byte_d = st_v[ch_d];
            default: byte_d = HAS_EXT ? tim_v[ch_d] : UNMAPPED;
        endcase

        rd_d.valid = rd_en;
        rd_d.data  = rd_q.data;
        if (rd_en) begin
            if (!addr[2]) begin
                rd_d.data = {24'h0, byte_d};
            end else if (size >= SZ_DWORD) begin
                rd_d.data = ptr_sel_d;
            end else if (size == SZ_WORD) begin
                rd_d.data = (ptr_sel_d >> {addr[1:0], 3'b000}) & 32'h0000_FFFF;
            end else begin
                rd_d.data = (ptr_sel_d >> {addr[1:0], 3'b000}) & 32'h0000_00FF;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata_o  = rd_q.data;
    assign rvalid_o = rd_q.valid;

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter bit HAS_EXT = 1'b1,
    localparam int AW     = $clog2(NUM_CH) + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_rd,
    input  logic                    acc_wr,
    input  logic [AW-1:0]           acc_addr,
    input  logic [1:0]              acc_size,
    input  logic [PTR_W-1:0]        acc_wdata,
    output logic [PTR_W-1:0]        acc_rdata,
    output logic                    acc_rvalid,
    input  logic [NUM_CH-1:0]       eng_done,
    input  logic [NUM_CH-1:0]       eng_err,
    input  logic [NUM_CH-1:0]       eng_intr,
    input  logic [NUM_CH-1:0]       drv_irq,
    output logic [NUM_CH-1:0]       dma_start,
    output logic [NUM_CH-1:0]       dma_cancel,
    output logic [NUM_CH-1:0]       dma_dir,
    output logic [NUM_CH*PTR_W-1:0] tbl_addr,
    output logic                    irq_out
);

    localparam int CW = AW - 3;

    logic [NUM_CH-1:0][7:0]       cmd_v;
    logic [NUM_CH-1:0][7:0]       st_v;
    logic [NUM_CH-1:0][7:0]       tim_v;
    logic [NUM_CH-1:0][PTR_W-1:0] ptr_v;
    logic [NUM_CH-1:0]            chan_active;
    logic [CW-1:0]                ch_sel;
    logic                         mode_wr;
    logic [7:0]                   mode_b;

    assign ch_sel  = acc_addr[AW-1:3];
    assign mode_wr = acc_wr && (acc_addr[2:0] == 3'd1);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        bmdma_chan #(.HAS_EXT(HAS_EXT)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (acc_wr && (ch_sel == CW'(c))),
            .off      (acc_addr[2:0]),
            .size     (acc_size),
            .wdata    (acc_wdata),
            .eng_done (eng_done[c]),
            .eng_err  (eng_err[c]),
            .eng_intr (eng_intr[c]),
            .cmd_o    (cmd_v[c]),
            .st_o     (st_v[c]),
            .tim_o    (tim_v[c]),
            .ptr_o    (ptr_v[c]),
            .start_o  (dma_start[c]),
            .cancel_o (dma_cancel[c])
        );
        assign dma_dir[c]                 = cmd_v[c][3];
        assign chan_active[c]             = st_v[c][0];
        assign tbl_addr[c*PTR_W +: PTR_W] = ptr_v[c];
    end

    if (HAS_EXT) begin : g_ext
        bmdma_mode #(.NUM_CH(NUM_CH)) u_mode (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (mode_wr),
            .blk_wdata (acc_wdata[4 +: NUM_CH]),
            .drv_irq   (drv_irq),
            .mode_o    (mode_b),
            .irq_o     (irq_out)
        );
    end else begin : g_noext
        logic unused_ext;
        assign unused_ext = ^{drv_irq, mode_wr};
        assign mode_b     = UNMAPPED;
        assign irq_out    = 1'b0;
    end

    bmdma_rdmux #(.NUM_CH(NUM_CH), .HAS_EXT(HAS_EXT)) u_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (acc_rd),
        .addr     (acc_addr),
        .size     (acc_size),
        .cmd_v    (cmd_v),
        .st_v     (st_v),
        .tim_v    (tim_v),
        .ptr_v    (ptr_v),
        .mode_b   (mode_b),
        .rdata_o  (acc_rdata),
        .rvalid_o (acc_rvalid)
    );

endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk #(
    parameter int NUM_CH = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 acc_rd,
    input logic                 acc_wr,
    input logic                 acc_rvalid,
    input logic [NUM_CH-1:0]    dma_start,
    input logic [NUM_CH-1:0]    dma_cancel,
    input logic [NUM_CH-1:0]    dma_dir,
    input logic [NUM_CH*32-1:0] tbl_addr,
    input logic [NUM_CH-1:0]    chan_active
);

    a_r12_rvalid_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> acc_rvalid);
    a_r12_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> !acc_rvalid);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        a_r3_start_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
            dma_start[c] |-> chan_active[c]);
        a_r3_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
            dma_start[c] |-> !$past(chan_active[c]));
        a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            dma_start[c] |=> !dma_start[c]);
        a_r4_cancel_idles: assert property (@(posedge clk) disable iff (!rst_n)
            dma_cancel[c] |-> !chan_active[c]);
        a_r4_start_cancel_excl: assert property (@(posedge clk) disable iff (!rst_n)
            !(dma_start[c] && dma_cancel[c]));
        a_r8_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
            tbl_addr[c*32 +: 2] == 2'b00);
        a_r8_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !acc_wr |=> $stable(tbl_addr[c*32 +: 32]));
        a_r2_dir_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !acc_wr |=> $stable(dma_dir[c]));
    end

endmodule

bind bmdma_regs bmdma_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_rd      (acc_rd),
    .acc_wr      (acc_wr),
    .acc_rvalid  (acc_rvalid),
    .dma_start   (dma_start),
    .dma_cancel  (dma_cancel),
    .dma_dir     (dma_dir),
    .tbl_addr    (tbl_addr),
    .chan_active (chan_active)
);

// File: tb/tb_bmdma_regs.sv
module tb_bmdma_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_rd = 1'b0;
    logic        acc_wr = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [1:0]  eng_done = '0;
    logic [1:0]  eng_err = '0;
    logic [1:0]  eng_intr = '0;
    logic [1:0]  drv_irq = '0;

    logic [31:0] acc_rdata, nx_rdata;
    logic        acc_rvalid, nx_rvalid;
    logic [1:0]  dma_start, dma_cancel, dma_dir;
    logic [1:0]  nx_start, nx_cancel, nx_dir;
    logic [63:0] tbl_addr, nx_tbl;
    logic        irq_out, nx_irq;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [1:0]  snap_start, snap_cancel;
    logic [31:0] rv, nrv;

    always #10 clk = ~clk;

    bmdma_regs dut (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid),
        .eng_done(eng_done), .eng_err(eng_err), .eng_intr(eng_intr),
        .drv_irq(drv_irq), .dma_start(dma_start), .dma_cancel(dma_cancel),
        .dma_dir(dma_dir), .tbl_addr(tbl_addr), .irq_out(irq_out)
    );

    bmdma_regs #(.HAS_EXT(1'b0)) dut_noext (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_rdata(nx_rdata), .acc_rvalid(nx_rvalid),
        .eng_done(eng_done), .eng_err(eng_err), .eng_intr(eng_intr),
        .drv_irq(drv_irq), .dma_start(nx_start), .dma_cancel(nx_cancel),
        .dma_dir(nx_dir), .tbl_addr(nx_tbl), .irq_out(nx_irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_eng(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d,
                          input logic [1:0] dn, input logic [1:0] er, input logic [1:0] it);
        @(negedge clk);
        acc_wr = 1'b1; acc_addr = a; acc_size = sz; acc_wdata = d;
        eng_done = dn; eng_err = er; eng_intr = it;
        @(negedge clk);
        snap_start = dma_start; snap_cancel = dma_cancel;
        acc_wr = 1'b0; eng_done = '0; eng_err = '0; eng_intr = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
        wr_eng(a, sz, d, 2'b00, 2'b00, 2'b00);
    endtask

    task automatic eng_pulse(input logic [1:0] dn, input logic [1:0] er, input logic [1:0] it);
        @(negedge clk);
        eng_done = dn; eng_err = er; eng_intr = it;
        @(negedge clk);
        eng_done = '0; eng_err = '0; eng_intr = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] sz);
        @(negedge clk);
        acc_rd = 1'b1; acc_addr = a; acc_size = sz;
        @(negedge clk);
        rv = acc_rdata; nrv = nx_rdata;
        check("R12 rvalid", 64'(acc_rvalid), 64'd1);
        acc_rd = 1'b0;
    endtask

    task automatic t_reset;
        rd(4'd0, 2'd0);  check("R1 cmd reset", 64'(rv), 64'h0);
        rd(4'd2, 2'd0);  check("R1 status reset", 64'(rv), 64'h0);
        rd(4'd4, 2'd2);  check("R1 pointer reset", 64'(rv), 64'h0);
        rd(4'd1, 2'd0);  check("R1 mode reset", 64'(rv), 64'h0);
        rd(4'd11, 2'd0); check("R1 timing reset", 64'(rv), 64'h0);
        check("R1 outputs reset", {59'h0, dma_start, dma_cancel, irq_out}, 64'h0);
        check("R1 table reset", tbl_addr, 64'h0);
    endtask

    task automatic t_command;
        wr(4'd0, 2'd0, 32'hFF);
        check("R3 start pulse", 64'(snap_start), 64'h1);
        rd(4'd0, 2'd0);  check("R2 cmd masked", 64'(rv), 64'h09);
        check("R2 dir out", 64'(dma_dir), 64'h1);
        rd(4'd2, 2'd0);  check("R3 active set", 64'(rv), 64'h01);
        wr(4'd0, 2'd0, 32'h09);
        check("R3 no restart", 64'(snap_start), 64'h0);
        wr(4'd0, 2'd0, 32'h08);
        check("R4 cancel pulse", 64'(snap_cancel), 64'h1);
        check("R4 no start", 64'(snap_start), 64'h0);
        rd(4'd2, 2'd0);  check("R4 active cleared", 64'(rv), 64'h00);
        rd(4'd0, 2'd1);  check("R12 zero-extended cmd", 64'(rv), 64'h08);
        wr(4'd0, 2'd0, 32'h00);
        check("R2 dir cleared", 64'(dma_dir), 64'h0);
    endtask

    task automatic t_status;
        wr(4'd0, 2'd0, 32'h01);
        eng_pulse(2'b00, 2'b01, 2'b01);
        rd(4'd2, 2'd0);  check("R6 err/intr set", 64'(rv), 64'h07);
        wr(4'd2, 2'd0, 32'hFF);
        rd(4'd2, 2'd0);  check("R5 w1c and load", 64'(rv), 64'h61);
        eng_pulse(2'b00, 2'b01, 2'b00);
        wr(4'd2, 2'd0, 32'h04);
        rd(4'd2, 2'd0);  check("R5 clear only bit2", 64'(rv), 64'h03);
        wr_eng(4'd2, 2'd0, 32'h02, 2'b00, 2'b01, 2'b00);
        rd(4'd2, 2'd0);  check("R6 set beats clear", 64'(rv), 64'h03);
        eng_pulse(2'b01, 2'b00, 2'b00);
        rd(4'd2, 2'd0);  check("R6 done clears active", 64'(rv), 64'h02);
        wr_eng(4'd0, 2'd0, 32'h01, 2'b01, 2'b00, 2'b00);
        check("R6 start with done pulses", 64'(snap_start), 64'h1);
        rd(4'd2, 2'd0);  check("R6 start beats done", 64'(rv), 64'h03);
        wr(4'd0, 2'd0, 32'h00);
        wr(4'd2, 2'd0, 32'h02);
        rd(4'd2, 2'd0);  check("R5 final clear", 64'(rv), 64'h00);
    endtask

    task automatic t_pointer;
        wr(4'd4, 2'd2, 32'hDEADBEEF);
        rd(4'd4, 2'd2);  check("R8 low bits zero", 64'(rv), 64'hDEADBEEC);
        check("R8 table out", 64'(tbl_addr[31:0]), 64'hDEADBEEC);
        wr(4'd6, 2'd0, 32'h5A);
        check("R7 byte lane 2", 64'(tbl_addr[31:0]), 64'hDE5ABEEC);
        wr(4'd4, 2'd1, 32'h1237);
        rd(4'd4, 2'd2);  check("R7 word lane 0", 64'(rv), 64'hDE5A1234);
        rd(4'd7, 2'd0);  check("R7 byte read lane 3", 64'(rv), 64'hDE);
        rd(4'd5, 2'd1);  check("R7 word read lane 1", 64'(rv), 64'h5A12);
        wr(4'd4, 2'd0, 32'hFF);
        rd(4'd4, 2'd2);  check("R8 byte low forced", 64'(rv), 64'hDE5A12FC);
        wr(4'd7, 2'd1, 32'hABCD);
        rd(4'd4, 2'd2);  check("R7 word at lane 3", 64'(rv), 64'hCD5A12FC);
        wr(4'd6, 2'd2, 32'h11223344);
        rd(4'd4, 2'd2);  check("R7 dword ignores lane", 64'(rv), 64'h11223344);
    endtask

    task automatic t_ext;
        wr(4'd1, 2'd0, 32'hFF);
        rd(4'd1, 2'd0);  check("R9 mode writable bits", 64'(rv), 64'h30);
        check("R9 noext offset1", 64'(nrv), 64'hFF);
        @(negedge clk); drv_irq = 2'b01;
        @(negedge clk);
        check("R10 blocked irq", 64'(irq_out), 64'h0);
        rd(4'd1, 2'd0);  check("R10 level visible", 64'(rv), 64'h34);
        wr(4'd1, 2'd0, 32'h00);
        check("R10 unblocked irq", 64'(irq_out), 64'h1);
        check("R9 noext no irq", 64'(nx_irq), 64'h0);
        wr(4'd9, 2'd0, 32'h10);
        check("R10 ch0 blocked via ch1 window", 64'(irq_out), 64'h0);
        rd(4'd9, 2'd0);  check("R9 shared mode", 64'(rv), 64'h14);
        @(negedge clk); drv_irq = 2'b10;
        @(negedge clk);
        check("R10 ch1 irq", 64'(irq_out), 64'h1);
        @(negedge clk); drv_irq = 2'b00;
        @(negedge clk);
        check("R10 irq drops", 64'(irq_out), 64'h0);
        wr(4'd3, 2'd0, 32'hA5);
        wr(4'd11, 2'd0, 32'h3C);
        rd(4'd3, 2'd0);  check("R9 timing ch0", 64'(rv), 64'hA5);
        check("R9 noext timing ignored", 64'(nrv), 64'hFF);
        rd(4'd11, 2'd0); check("R11 timing ch1", 64'(rv), 64'h3C);
    endtask

    task automatic t_chan1;
        wr(4'd8, 2'd0, 32'h09);
        check("R11 ch1 start only", 64'(snap_start), 64'h2);
        check("R11 ch1 dir", 64'(dma_dir), 64'h2);
        rd(4'd10, 2'd0); check("R11 ch1 active", 64'(rv), 64'h01);
        rd(4'd2, 2'd0);  check("R11 ch0 untouched", 64'(rv), 64'h00);
        wr(4'd12, 2'd2, 32'h87654321);
        check("R11 ch1 table", tbl_addr, 64'h87654320_11223344);
        rd(4'd14, 2'd1); check("R11 ch1 word read", 64'(rv), 64'h8765);
        wr(4'd8, 2'd0, 32'h00);
        check("R11 ch1 cancel", 64'(snap_cancel), 64'h2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_command();
        t_status();
        t_pointer();
        t_ext();
        t_chan1();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule